// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single memory-to-memory DMA channel driven by a chain of descriptors that sit in memory. Software places a descriptor address on `cfg_desc_addr` and then raises `cfg_enable`. On that rising edge the channel reads the six-word descriptor and copies the requested number of bytes, one 32-bit word at a time. Each word is a read from the running source address followed by a write to the running destination address. When a descriptor is finished, the channel either follows its link word to the next descriptor or ends the chain. A link that points back at its own descriptor repeats that descriptor for as long as enable stays high.

The memory side is one valid/ready request channel plus a read-response strobe. A request (`mem_req_valid` with its address, direction and write data) is held unchanged until the cycle in which `mem_req_ready` is high. That cycle transfers it, so memory applies back-pressure by holding ready low. The channel keeps at most one read outstanding and always accepts the response, which comes back as a one-cycle `mem_rsp_valid`. The status outputs and the three one-cycle event pulses (half-package, package-end, queue-end) are plain signals.

Top module: `chain_dma_channel`

## Requirements
- R1: A rising edge of `cfg_enable` while idle starts a fetch of six words at `cfg_desc_addr` + 0, 4, 8, 12, 16, 20, in that order. The words are, in order: a configuration word (fetched, no effect), the source address, the destination address, the byte count, the parameter word and the link address.
- R2: Each data word is read from the current source address and then written to the current destination address. Both addresses then advance by 4, and a byte count that is not a multiple of 4 moves ceil(count/4) words.
- R3: A request, once valid, keeps its valid, address and direction until it is accepted with `mem_req_ready`. Only enable falling may withdraw it.
- R4: In the parameter word, bits 7:0 give W and bits 15:8 give B. B is the block length in words, and a value of 0 means 1. After every full block, if words remain, the channel waits W clocks with no request before the next read.
- R5: While `cfg_pause` is high, no new request is raised and the inter-block wait does not count. When pause is released, the transfer resumes where it stopped and completes correctly.
- R6: `evt_half` pulses once per descriptor, in the cycle after the write that first leaves at most half of that descriptor's words remaining. A zero-length descriptor gives no half pulse.
- R7: `evt_pkg_end` pulses for one cycle when each descriptor completes. A byte count of 0 writes nothing but still gives this pulse.
- R8: A link of 0xFFFFF800 ends the chain: `evt_queue_end` pulses together with `evt_pkg_end` and the channel goes idle. It stays idle while enable stays high, until enable is lowered and raised again.
- R9: Any other link value makes the channel fetch the next descriptor at that address. A link equal to the descriptor's own address repeats it indefinitely, with no queue-end.
- R10: Lowering `cfg_enable` removes any request at once and leaves the channel idle from the next cycle.
- R11: `stat_src_addr` and `stat_dst_addr` show the next addresses to use. `stat_bytes_left` shows 4 × the words remaining, and `stat_busy` is high whenever the channel is not idle.
- R12: After reset the channel is idle, with no request and no events, and `stat_bytes_left` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Run control; rising edge starts, low aborts |
| cfg_pause | input | 1 | Freeze new requests and the wait counter |
| cfg_desc_addr | input | 32 | First descriptor address |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| stat_busy | output | 1 | Channel not idle |
| stat_src_addr | output | 32 | Current source address |
| stat_dst_addr | output | 32 | Current destination address |
| stat_bytes_left | output | LEN_W+1 | Bytes left in the descriptor, whole words |
| evt_half | output | 1 | Half-package pulse |
| evt_pkg_end | output | 1 | Descriptor-complete pulse |
| evt_queue_end | output | 1 | Chain-complete pulse |

## Verification
The bound assertions watch the cycle-level rules on every clock. They cover request stability under back-pressure, pause gating of new requests, the 4-byte step of the destination after each accepted write, queue-end coinciding with package-end and being followed by idle, and abort on enable low. Other behaviours can only be seen through scenarios: the fetch order, the copied data with rounding, the inter-block wait length (compared between two otherwise identical runs), the half-package pulse, chaining, looping, and resuming after pause. The bench shows these under both random and always-ready memory timing.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam logic [31:0] NULL_LINK = 32'hFFFF_F800;

  // descriptor word index; order is the fetch order
  localparam logic [2:0] F_CFG = 3'd0;
  localparam logic [2:0] F_SRC = 3'd1;
  localparam logic [2:0] F_DST = 3'd2;
  localparam logic [2:0] F_CNT = 3'd3;
  localparam logic [2:0] F_PRM = 3'd4;
  localparam logic [2:0] F_LNK = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_REQ, ST_FETCH_RSP, ST_RD_REQ,
    ST_RD_RSP, ST_WR_REQ, ST_GAP, ST_END
  } dma_state_e;
endpackage

// File: rtl/chain_dma_req_gate.sv
// Holds a raised request until accepted; pause only blocks raising a new one.
module chain_dma_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic pause,
  input  logic ready,
  output logic valid
);
  logic held;

  assign valid = want && (held || !pause);

  always_ff @(posedge clk) begin
    if (!rst_n) held <= 1'b0;
    else        held <= valid && !ready;
  end
endmodule

// File: rtl/chain_dma_wait_timer.sv
// Counts idle clocks between blocks; frozen when run is low.
module chain_dma_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         last
);
  logic [W-1:0] cnt;

  assign last = (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && cnt != '0)  cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/chain_dma_progress.sv
// Tracks words left in the descriptor and raises the half-way pulse once.
module chain_dma_progress #(
  parameter int LEN_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LEN_W-1:0]   byte_cnt,
  input  logic               step,
  output logic [LEN_W-2:0]   words_left,
  output logic               last_word,
  output logic               empty,
  output logic               half_pulse
);
  localparam int WL_W = LEN_W - 1;

  logic [WL_W-1:0] total;
  logic [WL_W-1:0] left_m1;
  logic [LEN_W:0]  rounded;
  logic            half_done;

  assign rounded   = {1'b0, byte_cnt} + (LEN_W+1)'(3);
  assign left_m1   = words_left - WL_W'(1);
  assign last_word = (words_left == WL_W'(1));
  assign empty     = (words_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total      <= '0;
      words_left <= '0;
      half_done  <= 1'b0;
      half_pulse <= 1'b0;
    end else begin
      half_pulse <= 1'b0;
      if (load) begin
        total      <= rounded[LEN_W:2];
        words_left <= rounded[LEN_W:2];
        half_done  <= 1'b0;
      end else if (step) begin
        words_left <= left_m1;
        if (!half_done && ({left_m1, 1'b0} <= {1'b0, total})) begin
          half_done  <= 1'b1;
          half_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int WAIT_W = 8,
  parameter int BLK_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_pause,
  input  logic [31:0]      cfg_desc_addr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [31:0]      mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             stat_busy,
  output logic [31:0]      stat_src_addr,
  output logic [31:0]      stat_dst_addr,
  output logic [LEN_W:0]   stat_bytes_left,
  output logic             evt_half,
  output logic             evt_pkg_end,
  output logic             evt_queue_end
);
  localparam int WL_W   = LEN_W - 1;
  localparam int BLK_LO = WAIT_W;
  localparam int BLK_HI = WAIT_W + BLK_W - 1;

  dma_state_e        state;
  logic              en_q;
  logic [2:0]        idx;
  logic [31:0]       desc_base, cur_src, cur_dst, link_addr, rd_data;
  logic [WAIT_W-1:0] wait_len;
  logic [BLK_W-1:0]  blk_len, blk_cnt, eff_blk;
  logic              req_want, accept;
  logic              prog_load, prog_step, prog_last, prog_empty, half_pulse;
  logic              timer_run, timer_last;
  logic [WL_W-1:0]   words_left;

  assign eff_blk  = (blk_len == '0) ? BLK_W'(1) : blk_len;
  assign req_want = cfg_enable &&
                    (state inside {ST_FETCH_REQ, ST_RD_REQ, ST_WR_REQ});
  assign accept   = mem_req_valid && mem_req_ready;

  chain_dma_req_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (req_want),
    .pause (cfg_pause),
    .ready (mem_req_ready),
    .valid (mem_req_valid)
  );

  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_wdata = rd_data;

  always_comb begin
    case (state)
      ST_FETCH_REQ: mem_req_addr = desc_base + {27'd0, idx, 2'b00};
      ST_RD_REQ:    mem_req_addr = cur_src;
      default:      mem_req_addr = cur_dst;
    endcase
  end

  assign prog_load = cfg_enable && (state == ST_FETCH_RSP) &&
                     mem_rsp_valid && (idx == F_CNT);
  assign prog_step = accept && (state == ST_WR_REQ);

  chain_dma_progress #(.LEN_W(LEN_W)) u_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (prog_load),
    .byte_cnt   (mem_rsp_data[LEN_W-1:0]),
    .step       (prog_step),
    .words_left (words_left),
    .last_word  (prog_last),
    .empty      (prog_empty),
    .half_pulse (half_pulse)
  );

  assign timer_run = cfg_enable && (state == ST_GAP) && !cfg_pause;

  chain_dma_wait_timer #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (prog_step),
    .load_val (wait_len),
    .run      (timer_run),
    .last     (timer_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      en_q      <= 1'b0;
      idx       <= '0;
      desc_base <= '0;
      cur_src   <= '0;
      cur_dst   <= '0;
      link_addr <= NULL_LINK;
      rd_data   <= '0;
      wait_len  <= '0;
      blk_len   <= '0;
      blk_cnt   <= '0;
    end else begin
      en_q <= cfg_enable;
      if (!cfg_enable) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (!en_q) begin
            desc_base <= cfg_desc_addr;
            idx       <= F_CFG;
            state     <= ST_FETCH_REQ;
          end
          ST_FETCH_REQ: if (accept) state <= ST_FETCH_RSP;
          ST_FETCH_RSP: if (mem_rsp_valid) begin
            case (idx)
              F_SRC: cur_src <= mem_rsp_data;
              F_DST: cur_dst <= mem_rsp_data;
              F_PRM: begin
                wait_len <= mem_rsp_data[WAIT_W-1:0];
                blk_len  <= mem_rsp_data[BLK_HI:BLK_LO];
              end
              F_LNK: link_addr <= mem_rsp_data;
              default: ;
            endcase
            if (idx == F_LNK) begin
              blk_cnt <= eff_blk;
              state   <= prog_empty ? ST_END : ST_RD_REQ;
            end else begin
              idx   <= idx + 3'd1;
              state <= ST_FETCH_REQ;
            end
          end
          ST_RD_REQ: if (accept) state <= ST_RD_RSP;
          ST_RD_RSP: if (mem_rsp_valid) begin
            rd_data <= mem_rsp_data;
            state   <= ST_WR_REQ;
          end
          ST_WR_REQ: if (accept) begin
            cur_src <= cur_src + 32'd4;
            cur_dst <= cur_dst + 32'd4;
            blk_cnt <= blk_cnt - BLK_W'(1);
            if (prog_last) begin
              state <= ST_END;
            end else if (blk_cnt == BLK_W'(1)) begin
              blk_cnt <= eff_blk;
              state   <= (wait_len == '0) ? ST_RD_REQ : ST_GAP;
            end else begin
              state <= ST_RD_REQ;
            end
          end
          ST_GAP: if (!cfg_pause && timer_last) state <= ST_RD_REQ;
          ST_END: begin
            if (link_addr == NULL_LINK) begin
              state <= ST_IDLE;
            end else begin
              desc_base <= link_addr;
              idx       <= F_CFG;
              state     <= ST_FETCH_REQ;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign stat_busy       = (state != ST_IDLE);
  assign stat_src_addr   = cur_src;
  assign stat_dst_addr   = cur_dst;
  assign stat_bytes_left = {words_left, 2'b00};
  assign evt_half        = half_pulse;
  assign evt_pkg_end     = (state == ST_END);
  assign evt_queue_end   = (state == ST_END) && (link_addr == NULL_LINK);
endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_enable,
  input logic        cfg_pause,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic        stat_busy,
  input logic [31:0] stat_dst_addr,
  input logic        evt_pkg_end,
  input logic        evt_queue_end
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (!cfg_enable || (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))));

  p_pause_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pause && !$past(mem_req_valid)) |-> !mem_req_valid);

  p_dst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (stat_dst_addr == $past(stat_dst_addr) + 32'd4));

  p_queue_with_pkg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_queue_end |-> evt_pkg_end);

  p_idle_after_queue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_queue_end && cfg_enable) |=> !stat_busy);

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !mem_req_valid);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !stat_busy);

  p_pkg_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkg_end |-> stat_busy);
endmodule

bind chain_dma_channel chain_dma_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_pause     (cfg_pause),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .stat_busy     (stat_busy),
  .stat_dst_addr (stat_dst_addr),
  .evt_pkg_end   (evt_pkg_end),
  .evt_queue_end (evt_queue_end)
);

// File: tb/chain_dma_channel_bench.sv
`timescale 1ns/1ps
module chain_dma_channel_bench;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam logic [31:0] NULLL = 32'hFFFF_F800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_pause = 1'b0;
  logic [31:0] cfg_desc_addr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        stat_busy;
  logic [31:0] stat_src_addr, stat_dst_addr;
  logic [32:0] stat_bytes_left;
  logic        evt_half, evt_pkg_end, evt_queue_end;

  always #10 clk = ~clk;

  chain_dma_channel u_chain_dma_channel (.*);

  int n_run = 0, n_fail = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem [0:1023];
  bit          rnd_mode = 1'b0;
  int          pend_cnt = 0;
  logic [9:0]  pend_idx = '0;
  int          wr_n = 0, rd_n = 0;
  logic [31:0] rd_log [0:15];

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[pend_idx];
      end
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[11:2]] <= mem_req_wdata;
        wr_n <= wr_n + 1;
      end else begin
        pend_cnt <= rnd_mode ? 1 + $urandom_range(2, 0) : 1;
        pend_idx <= mem_req_addr[11:2];
        if (rd_n < 16) rd_log[rd_n] <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
    end
    mem_req_ready <= rnd_mode ? ($urandom_range(2, 0) != 0) : 1'b1;
  end

  // ---------------- monitor ----------------
  int half_n = 0, pkg_n = 0, q_n = 0, viol_pause = 0, viol_hold = 0;
  logic pv = 1'b0, pr = 1'b0, pe = 1'b0;
  logic [31:0] pa = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_half)      half_n++;
      if (evt_pkg_end)   pkg_n++;
      if (evt_queue_end) q_n++;
      if (cfg_pause && mem_req_valid && !pv) viol_pause++;
      if (pv && !pr && pe && cfg_enable && (!mem_req_valid || mem_req_addr != pa))
        viol_hold++;
    end
    pv = mem_req_valid; pr = mem_req_ready; pe = cfg_enable; pa = mem_req_addr;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_words(input int nbytes);
    return (nbytes + 3) / 4;
  endfunction

  function automatic int exp_half(input int nbytes);
    return (nbytes > 0) ? 1 : 0;
  endfunction

  task automatic put_desc(input logic [31:0] base, src, dst, input int cnt,
                          input int wt, input int blk, input logic [31:0] link);
    mem[base[11:2] + 10'd0] = 32'h0000_5A01;
    mem[base[11:2] + 10'd1] = src;
    mem[base[11:2] + 10'd2] = dst;
    mem[base[11:2] + 10'd3] = cnt;
    mem[base[11:2] + 10'd4] = {16'h0, 8'(blk), 8'(wt)};
    mem[base[11:2] + 10'd5] = link;
  endtask

  task automatic fill(input logic [31:0] src, dst, input int nw);
    for (int i = 0; i < nw + 2; i++) begin
      mem[src[11:2] + 10'(i)] = $urandom;
      mem[dst[11:2] + 10'(i)] = SENT;
    end
  endtask

  task automatic check_copy(input logic [31:0] src, dst, input int nbytes, input string req);
    int w, bad;
    w = exp_words(nbytes);
    bad = 0;
    for (int i = 0; i < w; i++)
      if (mem[dst[11:2] + 10'(i)] !== mem[src[11:2] + 10'(i)]) bad++;
    if (mem[dst[11:2] + 10'(w)] !== SENT) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic start_ch(input logic [31:0] base);
    @(negedge clk);
    cfg_desc_addr = base;
    cfg_enable = 1'b1;
  endtask

  task automatic stop_ch();
    @(negedge clk);
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_q(input int maxc, output int cyc);
    int s;
    s = q_n;
    cyc = 0;
    while (q_n == s && cyc < maxc) begin
      @(posedge clk);
      cyc++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic run_tests();
    int cyc, d0, d5, p0, h0, q0, w0, r0, cnt, blk, wt;
    logic [32:0] bl1, bl2;
    logic [31:0] s1, d1;

    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!stat_busy && !mem_req_valid, "R12 idle/no request in reset", {stat_busy, mem_req_valid}, 0);
    chk(!evt_half && !evt_pkg_end && !evt_queue_end, "R12 no events in reset",
        {evt_half, evt_pkg_end, evt_queue_end}, 0);
    chk(stat_bytes_left == 0, "R12 bytes left zero", stat_bytes_left, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed: 20 bytes, block 2, no wait, null link
    fill(32'h400, 32'h800, 5);
    put_desc(32'h100, 32'h400, 32'h800, 20, 0, 2, NULLL);
    rd_n = 0; p0 = pkg_n; h0 = half_n; q0 = q_n;
    start_ch(32'h100);
    wait_q(2000, cyc);
    for (int k = 0; k < 6; k++)
      chk(rd_log[k] == 32'h100 + 32'(4 * k), "R1 descriptor fetch order", rd_log[k], 32'h100 + 4 * k);
    check_copy(32'h400, 32'h800, 20, "R2 copy 20 bytes");
    chk(pkg_n - p0 == 1, "R7 one package end", pkg_n - p0, 1);
    chk(half_n - h0 == 1, "R6 one half pulse", half_n - h0, 1);
    chk(q_n - q0 == 1, "R8 queue end on null link", q_n - q0, 1);
    @(negedge clk);
    chk(stat_bytes_left == 0, "R11 bytes left zero at end", stat_bytes_left, 0);
    chk(stat_dst_addr == 32'h814, "R11 final destination address", stat_dst_addr, 32'h814);
    r0 = rd_n;
    repeat (40) @(negedge clk);
    chk(!stat_busy && rd_n == r0, "R8 stays idle with enable high", {stat_busy, 8'(rd_n - r0)}, 0);
    stop_ch();

    // odd byte count rounds up
    fill(32'h400, 32'h800, 4);
    put_desc(32'h100, 32'h400, 32'h800, 13, 1, 3, NULLL);
    start_ch(32'h100);
    wait_q(2000, cyc);
    check_copy(32'h400, 32'h800, 13, "R2 13 bytes round to 4 words");
    stop_ch();

    // zero-length descriptor
    fill(32'h400, 32'h800, 1);
    put_desc(32'h100, 32'h400, 32'h800, 0, 0, 1, NULLL);
    p0 = pkg_n; h0 = half_n; w0 = wr_n;
    start_ch(32'h100);
    wait_q(2000, cyc);
    chk(wr_n == w0, "R7 zero count writes nothing", wr_n - w0, 0);
    chk(pkg_n - p0 == 1 && half_n == h0, "R7 zero count pkg end, no half",
        {8'(pkg_n - p0), 8'(half_n - h0)}, 16'h0100);
    stop_ch();

    // two-descriptor chain
    fill(32'h400, 32'h800, 6);
    fill(32'h600, 32'hA00, 3);
    put_desc(32'h100, 32'h400, 32'h800, 24, 2, 4, 32'h180);
    put_desc(32'h180, 32'h600, 32'hA00, 12, 0, 1, NULLL);
    p0 = pkg_n; q0 = q_n;
    start_ch(32'h100);
    wait_q(4000, cyc);
    check_copy(32'h400, 32'h800, 24, "R9 chain first descriptor");
    check_copy(32'h600, 32'hA00, 12, "R9 chain second descriptor");
    chk(pkg_n - p0 == 2 && q_n - q0 == 1, "R9 two package ends, one queue end",
        {8'(pkg_n - p0), 8'(q_n - q0)}, 16'h0201);
    stop_ch();

    // wait-cycle length: same transfer with W=0 and W=5, 8 words in blocks of 2
    rnd_mode = 1'b0;
    fill(32'h400, 32'h800, 8);
    put_desc(32'h100, 32'h400, 32'h800, 32, 0, 2, NULLL);
    start_ch(32'h100);
    wait_q(4000, d0);
    stop_ch();
    put_desc(32'h100, 32'h400, 32'h800, 32, 5, 2, NULLL);
    start_ch(32'h100);
    wait_q(4000, d5);
    stop_ch();
    chk(d5 - d0 == 5 * (exp_words(32) / 2 - 1), "R4 inter-block wait clocks", d5 - d0, 15);
    check_copy(32'h400, 32'h800, 32, "R4 copy with waits");

    // pause mid-transfer
    fill(32'h400, 32'h800, 16);
    put_desc(32'h100, 32'h400, 32'h800, 64, 3, 4, NULLL);
    viol_pause = 0;
    start_ch(32'h100);
    cyc = 0;
    while (stat_bytes_left != 64 && cyc < 2000) begin @(negedge clk); cyc++; end
    while (stat_bytes_left > 40 && cyc < 4000) begin @(negedge clk); cyc++; end
    cfg_pause = 1'b1;
    repeat (2) @(negedge clk);
    bl1 = stat_bytes_left; s1 = stat_src_addr; d1 = stat_dst_addr;
    chk(d1 - 32'h800 == 64 - 32'(bl1), "R11 destination matches progress", d1 - 32'h800, 64 - bl1);
    chk(s1 - 32'h400 == 64 - 32'(bl1), "R11 source matches progress", s1 - 32'h400, 64 - bl1);
    repeat (30) @(negedge clk);
    bl2 = stat_bytes_left;
    chk(bl2 == bl1 && stat_dst_addr == d1, "R5 no progress while paused", bl2, bl1);
    cfg_pause = 1'b0;
    wait_q(4000, cyc);
    check_copy(32'h400, 32'h800, 64, "R5 resume completes copy");
    chk(viol_pause == 0, "R5 no new request while paused", viol_pause, 0);
    stop_ch();

    // self-linked loop, then abort
    fill(32'h400, 32'h800, 2);
    put_desc(32'h200, 32'h400, 32'h800, 8, 1, 1, 32'h200);
    p0 = pkg_n; q0 = q_n;
    start_ch(32'h200);
    cyc = 0;
    while (pkg_n - p0 < 3 && cyc < 4000) begin @(posedge clk); cyc++; end
    chk(pkg_n - p0 >= 3 && q_n == q0, "R9 self link repeats without queue end",
        {8'(pkg_n - p0), 8'(q_n - q0)}, 16'h0300);
    @(negedge clk);
    cfg_enable = 1'b0;
    #1;
    chk(!mem_req_valid, "R10 request removed on disable", mem_req_valid, 0);
    @(negedge clk);
    chk(!stat_busy, "R10 idle after disable", stat_busy, 0);
    check_copy(32'h400, 32'h800, 8, "R9 loop data");
    repeat (6) @(negedge clk);

    // random descriptors under random memory timing
    rnd_mode = 1'b1;
    viol_hold = 0;
    for (int k = 0; k < 8; k++) begin
      cnt = $urandom_range(60, 0);
      blk = $urandom_range(3, 0);
      wt  = $urandom_range(3, 0);
      fill(32'h400, 32'h800, exp_words(cnt));
      put_desc(32'h140, 32'h400, 32'h800, cnt, wt, blk, NULLL);
      p0 = pkg_n; h0 = half_n;
      start_ch(32'h140);
      wait_q(6000, cyc);
      check_copy(32'h400, 32'h800, cnt, "R2 random copy");
      chk(half_n - h0 == exp_half(cnt), "R6 random half pulse", half_n - h0, exp_half(cnt));
      chk(pkg_n - p0 == 1, "R7 random package end", pkg_n - p0, 1);
      stop_ch();
    end
    chk(viol_hold == 0, "R3 request held until ready", viol_hold, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule